// File: doc/BRIEF.md
# CAN Acceptance Filter with Data-Byte Match

This block decides where a received CAN frame goes. It takes the header of the frame: the 11-bit base identifier, the 18-bit identifier extension, the extension flag, the length code and the first three payload bytes. It checks that header against a bank of filters. Each filter has an enable, an identifier pattern, a per-bit mask and a destination queue number. The block returns one registered result per frame. The result says whether the frame is accepted, which filter claimed it, which queue receives it, and whether the filter stage flagged an error.

A global data-compare count turns the extension half of every filter into a compare against the leading payload bits of base-format frames. It uses up to 18 bits: byte 0, then byte 1, then the top two bits of byte 2. This lets base-format traffic be steered by the payload as well as the identifier. Extended-format frames always compare all 29 identifier bits. The surrounding receiver supplies one frame per `frm_valid` pulse. It holds the filter configuration steady while frames are processed.

Top module: `can_acc_filter`

## Requirements
- R1: For every identifier bit, a mask bit of 1 requires the frame bit to equal the pattern bit. A mask bit of 0 makes that bit irrelevant.
- R2: A frame with `frm_ide`=1 is compared on all 11 base and 18 extension identifier bits. It ignores `data_cnt` and the length code, and it never raises `res_err`.
- R3: A base-format frame with `data_cnt`=0 is compared on its 11 base identifier bits only. The payload and the extension pattern have no effect.
- R4: For a base-format frame with `data_cnt`=N in 1..18, the payload vector is V = {byte0, byte1, byte2[7:6]}, with byte0 bit 7 at V[17]. Filter extension bit k (k = 0..N-1) is compared with V[17-k], subject to the mask.
- R5: Any `data_cnt` from 18 to 31 compares all 18 payload bits. The low six bits of byte 2 never take part.
- R6: A base-format frame with `data_cnt` other than 0 and `frm_dlc`=0 is a filter error. The result has `res_err`=1 and `res_accept`=0.
- R7: Disabled filters never match. When several enabled filters match, the lowest-numbered one wins. Its index is reported in `res_idx` and its destination in `res_dest`.
- R8: If the winning filter points at queue 0, which is reserved for the transmit queue, the frame is discarded. No other filter is tried.
- R9: If the winning filter points at a queue whose `q_is_tx` bit is 1, the frame is discarded. The same destination is accepted once that bit is 0.
- R10: If no enabled filter matches, the frame is discarded. A discarded frame reports `res_accept`=0, `res_idx`=0 and `res_dest`=0.
- R11: The result appears on the clock edge after `frm_valid` and lasts one cycle. With no frame, and during and after reset, all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame header present this cycle |
| frm_ide | input | 1 | Extended-format frame |
| frm_sid | input | 11 | Base identifier |
| frm_eid | input | 18 | Identifier extension |
| frm_dlc | input | 4 | Length code |
| frm_byte0 | input | 8 | Payload byte 0 |
| frm_byte1 | input | 8 | Payload byte 1 |
| frm_byte2 | input | 8 | Payload byte 2 |
| data_cnt | input | 5 | Number of leading payload bits compared on base frames |
| flt_en | input | NUM_FILT | Per-filter enable |
| flt_sid | input | NUM_FILT*11 | Base identifier patterns, filter k at [k*11 +: 11] |
| flt_eid | input | NUM_FILT*18 | Extension / payload patterns, filter k at [k*18 +: 18] |
| msk_sid | input | NUM_FILT*11 | Base identifier masks |
| msk_eid | input | NUM_FILT*18 | Extension / payload masks |
| flt_dest | input | NUM_FILT*DEST_W | Destination queue per filter |
| q_is_tx | input | NUM_QUEUE | 1 marks a queue that is transmit-only |
| res_valid | output | 1 | Result present |
| res_accept | output | 1 | Frame accepted |
| res_err | output | 1 | Filter error (payload compare on empty frame) |
| res_idx | output | IDX_W | Winning filter index |
| res_dest | output | DEST_W | Destination queue |

## Verification
The bench targets how payload bits are ordered. An extension bit paired with the wrong payload bit would accept 0x3F but reject 0x40 the wrong way round. A saturating count that stops short of 18, or that lets byte 2's low bits in, would flip the accept for counts 18, 20 and 31. The bench also checks that extended frames ignore the count even when the length is zero, and that an empty base frame under a nonzero count yields an error instead of a match. Finally, it checks priority and discard: a discarding winner must not hand the frame to a lower-priority filter, and a disabled filter must never claim a frame.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

    localparam int SID_W  = 11;
    localparam int EID_W  = 18;
    localparam int DLC_W  = 4;
    localparam int DCNT_W = 5;

    typedef struct packed {
        logic              ide;
        logic [SID_W-1:0]  sid;
        logic [EID_W-1:0]  eid;
        logic [DLC_W-1:0]  dlc;
        logic [7:0]        b0;
        logic [7:0]        b1;
        logic [7:0]        b2;
    } frame_t;

    typedef struct packed {
        logic [SID_W-1:0] sid;
        logic [EID_W-1:0] eid;
    } ident_t;

    // Payload bits reordered so that index k lines up with extension bit k:
    // k = 0 carries byte0 bit 7, k = 17 carries byte2 bit 6.
    function automatic logic [EID_W-1:0] payload_rev(input logic [7:0] b0,
                                                     input logic [7:0] b1,
                                                     input logic [7:0] b2);
        logic [EID_W-1:0] v;
        logic [EID_W-1:0] r;
        v = {b0, b1, b2[7:6]};
        for (int k = 0; k < EID_W; k++) r[k] = v[EID_W-1-k];
        return r;
    endfunction

    // Bits of the extension field that take part in a payload compare.
    function automatic logic [EID_W-1:0] payload_span(input logic [DCNT_W-1:0] n);
        logic [EID_W-1:0] m;
        for (int k = 0; k < EID_W; k++) m[k] = (DCNT_W'(k) < n);
        return m;
    endfunction

endpackage

// File: rtl/can_acc_cmp.sv
module can_acc_cmp
    import can_acc_pkg::*;
(
    input  logic              en,
    input  frame_t            frm,
    input  logic [DCNT_W-1:0] dcnt,
    input  ident_t            pat,
    input  ident_t            msk,
    output logic              hit
);
    logic             sid_ok;
    logic             eid_ok;
    logic [EID_W-1:0] eid_ref;
    logic [EID_W-1:0] eid_sel;

    always_comb begin
        sid_ok  = ((frm.sid ^ pat.sid) & msk.sid) == '0;
        eid_ref = frm.ide ? frm.eid : payload_rev(frm.b0, frm.b1, frm.b2);
        eid_sel = frm.ide ? '1 : payload_span(dcnt);
        eid_ok  = ((eid_ref ^ pat.eid) & msk.eid & eid_sel) == '0;
        hit     = en & sid_ok & eid_ok;
    end
endmodule

// File: rtl/can_acc_pick.sv
module can_acc_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
    import can_acc_pkg::*;
#(
    parameter int NUM_FILT  = 4,
    parameter int NUM_QUEUE = 32,
    localparam int IDX_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
    localparam int DEST_W   = (NUM_QUEUE > 1) ? $clog2(NUM_QUEUE) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frm_valid,
    input  logic                       frm_ide,
    input  logic [SID_W-1:0]           frm_sid,
    input  logic [EID_W-1:0]           frm_eid,
    input  logic [DLC_W-1:0]           frm_dlc,
    input  logic [7:0]                 frm_byte0,
    input  logic [7:0]                 frm_byte1,
    input  logic [7:0]                 frm_byte2,
    input  logic [DCNT_W-1:0]          data_cnt,
    input  logic [NUM_FILT-1:0]        flt_en,
    input  logic [NUM_FILT*SID_W-1:0]  flt_sid,
    input  logic [NUM_FILT*EID_W-1:0]  flt_eid,
    input  logic [NUM_FILT*SID_W-1:0]  msk_sid,
    input  logic [NUM_FILT*EID_W-1:0]  msk_eid,
    input  logic [NUM_FILT*DEST_W-1:0] flt_dest,
    input  logic [NUM_QUEUE-1:0]       q_is_tx,
    output logic                       res_valid,
    output logic                       res_accept,
    output logic                       res_err,
    output logic [IDX_W-1:0]           res_idx,
    output logic [DEST_W-1:0]          res_dest
);
    frame_t              frm;
    logic [NUM_FILT-1:0] hits;
    logic                any_hit;
    logic [IDX_W-1:0]    win;
    logic [DEST_W-1:0]   win_dest;
    logic                frm_err;
    logic                accept;

    assign frm = '{ide: frm_ide, sid: frm_sid, eid: frm_eid, dlc: frm_dlc,
                   b0: frm_byte0, b1: frm_byte1, b2: frm_byte2};

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_flt
        ident_t pat;
        ident_t msk;
        assign pat = '{sid: flt_sid[g*SID_W +: SID_W], eid: flt_eid[g*EID_W +: EID_W]};
        assign msk = '{sid: msk_sid[g*SID_W +: SID_W], eid: msk_eid[g*EID_W +: EID_W]};
        can_acc_cmp u_cmp (
            .en   (flt_en[g]),
            .frm  (frm),
            .dcnt (data_cnt),
            .pat  (pat),
            .msk  (msk),
            .hit  (hits[g])
        );
    end

    can_acc_pick #(.N(NUM_FILT), .IDX_W(IDX_W)) u_pick (
        .req (hits),
        .any (any_hit),
        .idx (win)
    );

    always_comb begin
        win_dest = flt_dest[win*DEST_W +: DEST_W];
        frm_err  = ~frm_ide & (data_cnt != '0) & (frm_dlc == '0);
        accept   = any_hit & ~frm_err & (win_dest != '0) & ~q_is_tx[win_dest];
    end

    always_ff @(posedge clk) begin
        if (rst || !frm_valid) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_err    <= 1'b0;
            res_idx    <= '0;
            res_dest   <= '0;
        end else begin
            res_valid  <= 1'b1;
            res_accept <= accept;
            res_err    <= frm_err;
            res_idx    <= accept ? win : '0;
            res_dest   <= accept ? win_dest : '0;
        end
    end
endmodule

// File: rtl/can_acc_filter_chk.sv
module can_acc_filter_chk #(
    parameter int NUM_FILT  = 4,
    parameter int NUM_QUEUE = 32,
    parameter int IDX_W     = 2,
    parameter int DEST_W    = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 frm_valid,
    input logic                 frm_ide,
    input logic [3:0]           frm_dlc,
    input logic [4:0]           data_cnt,
    input logic [NUM_FILT-1:0]  flt_en,
    input logic [NUM_QUEUE-1:0] q_is_tx,
    input logic                 res_valid,
    input logic                 res_accept,
    input logic                 res_err,
    input logic [IDX_W-1:0]     res_idx,
    input logic [DEST_W-1:0]    res_dest
);
    a_r11_result_follows: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_valid);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> (!res_valid && !res_accept && !res_err));

    a_r6_empty_payload_err: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ide && data_cnt != 5'd0 && frm_dlc == 4'd0)
        |=> (res_err && !res_accept));

    a_r2_ext_no_err: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ide) |=> !res_err);

    a_r8_dest_nonzero: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> res_dest != '0);

    a_r9_not_tx_queue: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> !q_is_tx[res_dest]);

    a_r7_winner_enabled: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> flt_en[res_idx]);

    a_r10_discard_zeroed: assert property (@(posedge clk) disable iff (rst)
        !res_accept |-> (res_idx == '0 && res_dest == '0));
endmodule

bind can_acc_filter can_acc_filter_chk #(
    .NUM_FILT(NUM_FILT), .NUM_QUEUE(NUM_QUEUE), .IDX_W(IDX_W), .DEST_W(DEST_W)
) u_chk (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ide(frm_ide),
    .frm_dlc(frm_dlc), .data_cnt(data_cnt), .flt_en(flt_en), .q_is_tx(q_is_tx),
    .res_valid(res_valid), .res_accept(res_accept), .res_err(res_err),
    .res_idx(res_idx), .res_dest(res_dest)
);

// File: tb/can_acc_filter_test.sv
module can_acc_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int NQ = 32;

    typedef struct packed {
        logic [3:0]  req;
        logic        ide;
        logic [10:0] sid;
        logic [17:0] eid;
        logic [3:0]  dlc;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [4:0]  n;
        logic        acc;
        logic [1:0]  idx;
        logic [4:0]  dest;
        logic        err;
    } vec_t;

    localparam int NV = 20;
    localparam logic [75:0] TBL [0:NV-1] = '{
        {4'd7,  1'b0, 11'h123, 18'h00000, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0,  1'b1, 2'd0, 5'd1, 1'b0}, // R7 F0 beats F1
        {4'd1,  1'b0, 11'h12A, 18'h00000, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0,  1'b1, 2'd1, 5'd2, 1'b0}, // R1 masked low bits
        {4'd10, 1'b0, 11'h133, 18'h00000, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0,  1'b0, 2'd0, 5'd0, 1'b0}, // R10 no match
        {4'd3,  1'b0, 11'h555, 18'h00000, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0,  1'b1, 2'd2, 5'd3, 1'b0}, // R3 payload ignored
        {4'd4,  1'b0, 11'h555, 18'h00000, 4'd1, 8'hFF, 8'h00, 8'h00, 5'd8,  1'b1, 2'd2, 5'd3, 1'b0}, // R4 byte0 all ones
        {4'd4,  1'b0, 11'h555, 18'h00000, 4'd1, 8'hFE, 8'h00, 8'h00, 5'd8,  1'b0, 2'd0, 5'd0, 1'b0}, // R4 byte0 bit0 off
        {4'd4,  1'b0, 11'h555, 18'h00000, 4'd2, 8'hFF, 8'h7F, 8'h00, 5'd9,  1'b0, 2'd0, 5'd0, 1'b0}, // R4 ninth bit = byte1[7]
        {4'd4,  1'b0, 11'h123, 18'h00000, 4'd8, 8'h3F, 8'h00, 8'h00, 5'd2,  1'b1, 2'd0, 5'd1, 1'b0}, // R4 top two bits zero
        {4'd4,  1'b0, 11'h123, 18'h00000, 4'd8, 8'h40, 8'h00, 8'h00, 5'd2,  1'b1, 2'd1, 5'd2, 1'b0}, // R4 byte0[6] breaks F0
        {4'd5,  1'b0, 11'h555, 18'h00000, 4'd3, 8'hFF, 8'hFF, 8'hC0, 5'd18, 1'b1, 2'd2, 5'd3, 1'b0}, // R5 full 18
        {4'd5,  1'b0, 11'h555, 18'h00000, 4'd3, 8'hFF, 8'hFF, 8'h80, 5'd31, 1'b0, 2'd0, 5'd0, 1'b0}, // R5 byte2[6] checked
        {4'd5,  1'b0, 11'h555, 18'h00000, 4'd3, 8'hFF, 8'hFF, 8'hFF, 5'd31, 1'b1, 2'd2, 5'd3, 1'b0}, // R5 low bits unused
        {4'd5,  1'b0, 11'h555, 18'h00000, 4'd3, 8'hFF, 8'hFF, 8'hC0, 5'd20, 1'b1, 2'd2, 5'd3, 1'b0}, // R5 count 20
        {4'd5,  1'b0, 11'h555, 18'h00000, 4'd3, 8'hFF, 8'hFF, 8'h40, 5'd20, 1'b0, 2'd0, 5'd0, 1'b0}, // R5 byte2[7] checked
        {4'd6,  1'b0, 11'h555, 18'h00000, 4'd0, 8'h00, 8'h00, 8'h00, 5'd4,  1'b0, 2'd0, 5'd0, 1'b1}, // R6 empty payload
        {4'd6,  1'b0, 11'h123, 18'h00000, 4'd0, 8'h00, 8'h00, 8'h00, 5'd1,  1'b0, 2'd0, 5'd0, 1'b1}, // R6 would match F0
        {4'd2,  1'b1, 11'h123, 18'h00000, 4'd0, 8'hFF, 8'hFF, 8'hFF, 5'd8,  1'b1, 2'd0, 5'd1, 1'b0}, // R2 count ignored
        {4'd2,  1'b1, 11'h123, 18'h00001, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0,  1'b1, 2'd1, 5'd2, 1'b0}, // R2 eid breaks F0
        {4'd2,  1'b1, 11'h555, 18'h3FFFF, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0,  1'b1, 2'd2, 5'd3, 1'b0}, // R2 full eid
        {4'd2,  1'b1, 11'h555, 18'h3FFFE, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0,  1'b0, 2'd0, 5'd0, 1'b0}  // R2 eid bit0 off
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frm_valid = 1'b0;
    logic          frm_ide = 1'b0;
    logic [10:0]   frm_sid = '0;
    logic [17:0]   frm_eid = '0;
    logic [3:0]    frm_dlc = '0;
    logic [7:0]    frm_byte0 = '0, frm_byte1 = '0, frm_byte2 = '0;
    logic [4:0]    data_cnt = '0;
    logic [NF-1:0]    flt_en = '0;
    logic [NF*11-1:0] flt_sid = '0, msk_sid = '0;
    logic [NF*18-1:0] flt_eid = '0, msk_eid = '0;
    logic [NF*5-1:0]  flt_dest = '0;
    logic [NQ-1:0]    q_is_tx = '0;
    logic          res_valid, res_accept, res_err;
    logic [1:0]    res_idx;
    logic [4:0]    res_dest;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_acc_filter #(.NUM_FILT(NF), .NUM_QUEUE(NQ)) uut (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ide(frm_ide),
        .frm_sid(frm_sid), .frm_eid(frm_eid), .frm_dlc(frm_dlc),
        .frm_byte0(frm_byte0), .frm_byte1(frm_byte1), .frm_byte2(frm_byte2),
        .data_cnt(data_cnt), .flt_en(flt_en), .flt_sid(flt_sid), .flt_eid(flt_eid),
        .msk_sid(msk_sid), .msk_eid(msk_eid), .flt_dest(flt_dest), .q_is_tx(q_is_tx),
        .res_valid(res_valid), .res_accept(res_accept), .res_err(res_err),
        .res_idx(res_idx), .res_dest(res_dest)
    );

    task automatic set_flt(input int k, input logic en, input logic [10:0] sid,
                           input logic [10:0] msid, input logic [17:0] eid,
                           input logic [17:0] meid, input logic [4:0] dest);
        flt_en[k]            = en;
        flt_sid[k*11 +: 11]  = sid;
        msk_sid[k*11 +: 11]  = msid;
        flt_eid[k*18 +: 18]  = eid;
        msk_eid[k*18 +: 18]  = meid;
        flt_dest[k*5 +: 5]   = dest;
    endtask

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got {valid,acc,idx,dest,err}=%b expected %b", tag, got, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, sampled at the negedge after
    task automatic send(input logic ide, input logic [10:0] sid, input logic [17:0] eid,
                        input logic [3:0] dlc, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [4:0] n);
        frm_ide = ide; frm_sid = sid; frm_eid = eid; frm_dlc = dlc;
        frm_byte0 = b0; frm_byte1 = b1; frm_byte2 = b2; data_cnt = n;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    function automatic logic [9:0] outs();
        return {res_valid, res_accept, res_idx, res_dest, res_err};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        set_flt(0, 1'b1, 11'h123, 11'h7FF, 18'h00000, 18'h3FFFF, 5'd1);
        set_flt(1, 1'b1, 11'h120, 11'h7F0, 18'h2AAAA, 18'h00000, 5'd2);
        set_flt(2, 1'b1, 11'h555, 11'h7FF, 18'h3FFFF, 18'h3FFFF, 5'd3);
        set_flt(3, 1'b0, 11'h555, 11'h7FF, 18'h00000, 18'h00000, 5'd4);

        // R11 reset with a frame presented
        @(negedge clk);
        frm_valid = 1'b1; frm_sid = 11'h123;
        repeat (3) @(negedge clk);
        check("R11 reset state", outs(), 10'b0);
        frm_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            send(v.ide, v.sid, v.eid, v.dlc, v.b0, v.b1, v.b2, v.n);
            check($sformatf("R%0d vector %0d", v.req, i), outs(),
                  {1'b1, v.acc, v.idx, v.dest, v.err});
        end

        // R11 result lasts one cycle
        @(negedge clk);
        check("R11 idle after result", outs(), 10'b0);

        // R8 winner pointing at queue 0 discards, lower filter not used
        set_flt(0, 1'b1, 11'h123, 11'h7FF, 18'h00000, 18'h3FFFF, 5'd0);
        send(1'b0, 11'h123, 18'h0, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0);
        check("R8 queue zero discard", outs(), {1'b1, 1'b0, 2'd0, 5'd0, 1'b0});

        // R9 transmit queue discards, then accepted once cleared
        set_flt(0, 1'b1, 11'h123, 11'h7FF, 18'h00000, 18'h3FFFF, 5'd5);
        q_is_tx[5] = 1'b1;
        send(1'b0, 11'h123, 18'h0, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0);
        check("R9 transmit queue discard", outs(), {1'b1, 1'b0, 2'd0, 5'd0, 1'b0});
        q_is_tx[5] = 1'b0;
        send(1'b0, 11'h123, 18'h0, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0);
        check("R9 receive queue accepted", outs(), {1'b1, 1'b1, 2'd0, 5'd5, 1'b0});

        // R7 enable the last filter, disable filter 2
        set_flt(2, 1'b0, 11'h555, 11'h7FF, 18'h3FFFF, 18'h3FFFF, 5'd3);
        set_flt(3, 1'b1, 11'h555, 11'h7FF, 18'h00000, 18'h00000, 5'd4);
        send(1'b0, 11'h555, 18'h0, 4'd8, 8'h00, 8'h00, 8'h00, 5'd0);
        check("R7 highest index filter", outs(), {1'b1, 1'b1, 2'd3, 5'd4, 1'b0});

        // R11 reset during a frame suppresses the result
        frm_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0; rst = 1'b0;
        check("R11 reset over frame", outs(), 10'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule